// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block is a numerically controlled oscillator for a colour subcarrier. On every edge of the double-rate sample clock it adds a 23-bit unsigned frequency word to a 23-bit phase register. The phase register wraps around naturally. The resulting phase is meant to address a sine table elsewhere in the chip. The output frequency is the sample clock frequency multiplied by the word and divided by 2^23.

The frequency word sits in a holding register that changes only on a load strobe. That register is also presented on a port, so that a serial genlock transmitter can send the word to a slave device. A synchronous zeroing strobe clears the phase in the same cycle in which the transmitter sends its active-low reset bit. A slave that locks to that bit therefore starts from the same phase origin.

Top module: `subcarrier_nco`

## Requirements
- R1: After a cycle with `rst` high, `phase` and `freq_word` both read 0.
- R2: On each clock edge with `rst` and `phase_zero` low, `phase` becomes its previous value plus the `freq_word` value held before that edge.
- R3: The phase addition wraps modulo 2^23 without saturating. With a word of 0x7FFFFF, the phase sequence from 0 is 0x7FFFFF, 0x7FFFFE, 0x7FFFFD. With a word of 0x400000, the phase alternates between 0x400000 and 0.
- R4: When `word_load` is high at an edge, `freq_word` takes the value of `word_in` after that edge. The accumulator still adds the old word at that edge and adds the new word from the following edge on.
- R5: While `word_load` is low, `freq_word` keeps its value and changes on `word_in` have no effect.
- R6: When `phase_zero` is high at an edge, `phase` is 0 after that edge, whatever the word. The next edge without zeroing gives `phase` equal to the word.
- R7: When `phase_zero` and `word_load` are high at the same edge, `phase` becomes 0 and `freq_word` takes the new word. The next edge then gives `phase` equal to the new word.
- R8: `rst` has priority over `word_load` and `phase_zero`. A load that arrives during reset is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate sample clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | W (23) | New frequency word |
| word_load | input | 1 | Copies `word_in` into the holding register |
| phase_zero | input | 1 | Forces the phase to zero at this edge |
| phase | output | W (23) | Current accumulator phase |
| freq_word | output | W (23) | Word in use, passed to the genlock transmitter |

## Verification
Wraparound is the hardest behaviour to reach from the ports. A small word would need millions of cycles before the phase passes 2^23. The bench therefore loads near-full-scale and half-scale words, which force a wrap on every step. It also puts a load and a zeroing strobe on the same edge. This checks that the old word is not added in that cycle and that the new word is added in the next one.

// File: rtl/subcarrier_nco.sv
module subcarrier_nco #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_in,
  input  logic         word_load,
  input  logic         phase_zero,
  output logic [W-1:0] phase,
  output logic [W-1:0] freq_word
);

  logic [W-1:0] acc_q, word_q;
  logic [W-1:0] acc_next;

  assign acc_next  = phase_zero ? '0 : acc_q + word_q;
  assign phase     = acc_q;
  assign freq_word = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      acc_q <= acc_next;
      if (word_load) word_q <= word_in;
    end
  end

endmodule

// File: rtl/subcarrier_nco_chk.sv
module subcarrier_nco_chk #(
  parameter int W = 23
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] word_in,
  input logic         word_load,
  input logic         phase_zero,
  input logic [W-1:0] phase,
  input logic [W-1:0] freq_word
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rst)) |-> (phase == '0 && freq_word == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !phase_zero) |=> phase == W'($past(phase) + $past(freq_word)));

  // R4
  word_load_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && word_load) |=> freq_word == $past(word_in));

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !word_load) |=> $stable(freq_word));

  // R6
  phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && phase_zero) |=> phase == '0);

endmodule

bind subcarrier_nco subcarrier_nco_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .word_in(word_in), .word_load(word_load),
  .phase_zero(phase_zero), .phase(phase), .freq_word(freq_word)
);

// File: tb/subcarrier_nco_test.sv
module subcarrier_nco_test;
  localparam int W = 23;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] word_in = '0;
  logic         word_load = 1'b0;
  logic         phase_zero = 1'b0;
  logic [W-1:0] phase, freq_word;
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  subcarrier_nco #(.W(W)) uut (
    .clk(clk), .rst(rst), .word_in(word_in), .word_load(word_load),
    .phase_zero(phase_zero), .phase(phase), .freq_word(freq_word)
  );

  // {phase_zero, word_load, word_in, expected phase, expected word}
  localparam logic [2*1+3*W-1:0] VEC [N] = '{
    {1'b0, 1'b1, 23'd100,  23'd0,    23'd100},  // R4 load, old word 0 added
    {1'b0, 1'b0, 23'd555,  23'd100,  23'd100},  // R5 input ignored, R2 step
    {1'b0, 1'b0, 23'd0,    23'd200,  23'd100},  // R2
    {1'b0, 1'b1, 23'd1000, 23'd300,  23'd1000}, // R4
    {1'b0, 1'b0, 23'd0,    23'd1300, 23'd1000}, // R4 new word now used
    {1'b1, 1'b0, 23'd0,    23'd0,    23'd1000}, // R6
    {1'b0, 1'b0, 23'd0,    23'd1000, 23'd1000}, // R6 restart
    {1'b1, 1'b1, 23'd7,    23'd0,    23'd7},    // R7
    {1'b0, 1'b0, 23'd0,    23'd7,    23'd7},    // R7 next step
    {1'b0, 1'b0, 23'd9,    23'd14,   23'd7}     // R2
  };

  task automatic check(input string req, input logic [W-1:0] exp_p, input logic [W-1:0] exp_w);
    compared++;
    if (phase !== exp_p || freq_word !== exp_w) begin
      mismatched++;
      $display("FAIL %s: phase=%0h word=%0h expected phase=%0h word=%0h",
               req, phase, freq_word, exp_p, exp_w);
    end
  endtask

  task automatic step(input logic z, input logic ld, input logic [W-1:0] w);
    phase_zero = z; word_load = ld; word_in = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 1'b0, '0);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1", '0, '0);

    for (int i = 0; i < N; i++) begin
      step(VEC[i][2*1+3*W-1], VEC[i][2*1+3*W-2], VEC[i][3*W-1:2*W]);
      check("R2/R4/R5/R6/R7 vector", VEC[i][2*W-1:W], VEC[i][W-1:0]);
    end

    // R3 wrap with near-full-scale word
    do_reset();
    step(1'b0, 1'b1, 23'h7FFFFF);
    check("R3", 23'h0, 23'h7FFFFF);
    step(1'b0, 1'b0, '0);
    check("R3", 23'h7FFFFF, 23'h7FFFFF);
    step(1'b0, 1'b0, '0);
    check("R3", 23'h7FFFFE, 23'h7FFFFF);
    step(1'b0, 1'b0, '0);
    check("R3", 23'h7FFFFD, 23'h7FFFFF);

    // R3 half-scale alternation
    do_reset();
    step(1'b0, 1'b1, 23'h400000);
    step(1'b0, 1'b0, '0);
    check("R3", 23'h400000, 23'h400000);
    step(1'b0, 1'b0, '0);
    check("R3", 23'h0, 23'h400000);
    step(1'b0, 1'b0, '0);
    check("R3", 23'h400000, 23'h400000);

    // R8 reset beats load and zeroing
    rst = 1'b1;
    step(1'b1, 1'b1, 23'd123);
    rst = 1'b0;
    check("R8", '0, '0);
    step(1'b0, 1'b0, '0);
    check("R8", '0, '0);

    // R1 reset after activity
    step(1'b0, 1'b1, 23'd42);
    step(1'b0, 1'b0, '0);
    do_reset();
    check("R1", '0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule